// File: doc/BRIEF.md
# Width-Selectable Iterative Multiply/Divide Unit

This block performs unsigned multiplication or unsigned division on two register operands. It produces one result bit per clock, and the surrounding core stalls while it runs. The first operand comes from the accumulator and the second from the X index register. The double-width answer goes back split across the two: for multiply, the accumulator receives the low half of the product and X the high half; for divide, the accumulator receives the quotient and X the remainder.

Only the accumulator width flag selects the operating width. In narrow mode (8 bits) an operation is busy for exactly 11 cycles. In wide mode (16 bits) it is busy for exactly 19 cycles, whatever the X width flag says. When the accumulator is wide and X is narrow, the unit still spends all 19 cycles, but X supplies only its low byte and the top byte of the X result is forced to zero.

The controller walks five states. IDLE goes to LOAD when start is seen; this is the accept transition, and the operands and flags are captured at that edge. LOAD goes to STEP after it clears the working registers. STEP repeats once per result bit and goes to FIX after the last bit. FIX goes to DONE as it aligns and writes back the results. DONE goes back to IDLE, and done is high during that cycle.

Top module: `muldiv_unit`

## Requirements
- R1: With acc_wide low at acceptance, busy is high for exactly 11 consecutive cycles, starting the cycle after the start edge. done is high only in the last of those cycles, for one cycle.
- R2: With acc_wide high at acceptance, busy is high for exactly 19 cycles and done pulses in the last one. idx_wide has no effect on this count.
- R3: Narrow multiply (acc_wide=0, op_div=0) multiplies a_in[7:0] by x_in[7:0], whatever idx_wide is. The product bits 7:0 appear on a_out[7:0] and bits 15:8 on x_out[7:0]. Bits 15:8 of both outputs are zero, and bits 15:8 of both inputs are ignored.
- R4: Wide multiply with idx_wide=1 gives product bits 15:0 on a_out and bits 31:16 on x_out.
- R5: Divide (op_div=1) with a nonzero divisor puts the quotient of dividend a_in by divisor x_in on a_out and the remainder on x_out. In narrow mode both operands are low bytes.
- R6: Division by zero does not trap. The quotient is all ones at the active width (0x00FF narrow, 0xFFFF wide), and the remainder equals the dividend.
- R7: With acc_wide=1 and idx_wide=0, the second operand is x_in[7:0] only, and x_out[15:8] is zero even when the full result would be nonzero there.
- R8: start is ignored while busy. a_out and x_out change only in the cycle where done is high, and they hold their value until the next completion.
- R9: While rst_n is low, busy, done, a_out and x_out are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation; accepted only when idle |
| op_div | input | 1 | 0 = multiply, 1 = divide |
| acc_wide | input | 1 | Accumulator width flag: 1 = 16-bit operation |
| idx_wide | input | 1 | X width flag: 0 limits the second operand and the X result to a byte |
| a_in | input | 16 | Accumulator operand (multiplicand or dividend) |
| x_in | input | 16 | X operand (multiplier or divisor) |
| busy | output | 1 | High for the whole operation |
| done | output | 1 | One-cycle pulse when the results are valid |
| a_out | output | 16 | Low product half or quotient |
| x_out | output | 16 | High product half or remainder |

## Verification
Multiply runs with all-ones operands, to reach the largest carry chains, and with operands whose upper input bytes are nonzero, which shows that narrow mode really ignores them. Divide runs with a divisor larger than the dividend (quotient zero), with a power-of-two divisor, and with a zero divisor in each width, which separates the defined zero-divisor result from ordinary restoring behaviour. Mixed-width runs pair a wide accumulator with a narrow X whose upper byte is set, so a missing operand mask or a missing result truncation shows up as a wrong X value. Each run also counts busy cycles, which tells the two latencies apart and shows that idx_wide leaves the count unchanged.

// File: rtl/muldiv_pkg.sv
package muldiv_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOAD,
        ST_STEP,
        ST_FIX,
        ST_DONE
    } md_state_e;

    localparam int FIXED_OVERHEAD = 3;

endpackage

// File: rtl/muldiv_ctrl.sv
module muldiv_ctrl
    import muldiv_pkg::*;
#(
    parameter int WIDE_W   = 16,
    parameter int NARROW_W = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic wide,
    output logic busy,
    output logic done,
    output logic accept,
    output logic load_en,
    output logic step_en,
    output logic wb_en
);

    localparam int CW = $clog2(WIDE_W);
    localparam int LW = $clog2(WIDE_W + FIXED_OVERHEAD + 1) + 1;

    md_state_e state_q, state_d;
    logic [CW-1:0] cnt_q;
    logic          last_step;

    assign last_step = wide ? (cnt_q == CW'(WIDE_W - 1))
                            : (cnt_q == CW'(NARROW_W - 1));

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start) state_d = ST_LOAD;
            ST_LOAD: state_d = ST_STEP;
            ST_STEP: if (last_step) state_d = ST_FIX;
            ST_FIX:  state_d = ST_DONE;
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_LOAD)      cnt_q <= '0;
            else if (state_q == ST_STEP) cnt_q <= cnt_q + 1'b1;
        end
    end

    always_comb begin
        busy    = 1'b1;
        done    = 1'b0;
        accept  = 1'b0;
        load_en = 1'b0;
        step_en = 1'b0;
        wb_en   = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                busy   = 1'b0;
                accept = start;
            end
            ST_LOAD: load_en = 1'b1;
            ST_STEP: step_en = 1'b1;
            ST_FIX:  wb_en   = 1'b1;
            ST_DONE: done    = 1'b1;
            default: busy    = 1'b0;
        endcase
    end

    // Independent cycle counter used only to check the latency.
    logic [LW-1:0] lat_q;
    always_ff @(posedge clk) begin
        if (!rst_n)      lat_q <= '0;
        else if (accept) lat_q <= LW'(1);
        else if (busy)   lat_q <= lat_q + 1'b1;
    end

    p_done_in_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy);

    p_done_single_r1: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (lat_q == (wide ? LW'(WIDE_W + FIXED_OVERHEAD)
                                 : LW'(NARROW_W + FIXED_OVERHEAD))));

    p_start_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy);

endmodule

// File: rtl/muldiv_engine.sv
module muldiv_engine #(
    parameter int WIDE_W   = 16,
    parameter int NARROW_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_en,
    input  logic              step_en,
    input  logic              op_div,
    input  logic              wide,
    input  logic [WIDE_W-1:0] a_op,
    input  logic [WIDE_W-1:0] x_op,
    output logic [WIDE_W-1:0] res_lo,
    output logic [WIDE_W-1:0] res_hi
);

    localparam int SH = WIDE_W - NARROW_W;

    logic [WIDE_W-1:0]   hi_q, lo_q, d_q;
    logic [WIDE_W:0]     add_sum;
    logic [WIDE_W:0]     shifted;
    logic [WIDE_W+1:0]   trial;
    logic                borrow;
    logic [2*WIDE_W-1:0] full;

    // Multiply: add the multiplicand into the top half when the low bit is set.
    assign add_sum = {1'b0, hi_q} + (lo_q[0] ? {1'b0, d_q} : '0);
    // Divide: shift in the next dividend bit, then trial-subtract.
    assign shifted = {hi_q, lo_q[WIDE_W-1]};
    assign trial   = {1'b0, shifted} - {2'b00, d_q};
    assign borrow  = trial[WIDE_W+1];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_q <= '0;
            lo_q <= '0;
            d_q  <= '0;
        end else if (load_en) begin
            hi_q <= '0;
            d_q  <= x_op;
            if (op_div && !wide) lo_q <= a_op << SH;
            else                 lo_q <= a_op;
        end else if (step_en) begin
            if (op_div) begin
                hi_q <= borrow ? shifted[WIDE_W-1:0] : trial[WIDE_W-1:0];
                lo_q <= {lo_q[WIDE_W-2:0], ~borrow};
            end else begin
                hi_q <= add_sum[WIDE_W:1];
                lo_q <= {add_sum[0], lo_q[WIDE_W-1:1]};
            end
        end
    end

    assign full = {hi_q, lo_q};

    always_comb begin
        if (op_div) begin
            res_lo = wide ? lo_q : {{SH{1'b0}}, lo_q[NARROW_W-1:0]};
            res_hi = hi_q;
        end else if (wide) begin
            res_lo = full[WIDE_W-1:0];
            res_hi = full[2*WIDE_W-1:WIDE_W];
        end else begin
            res_lo = {{SH{1'b0}}, full[SH+NARROW_W-1:SH]};
            res_hi = {{SH{1'b0}}, full[SH+2*NARROW_W-1:SH+NARROW_W]};
        end
    end

    // Restoring invariant: the partial remainder stays below a nonzero divisor.
    p_rem_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && op_div && d_q != '0) |=> (hi_q < d_q));

endmodule

// File: rtl/muldiv_unit.sv
module muldiv_unit #(
    parameter int WIDE_W   = 16,
    parameter int NARROW_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              op_div,
    input  logic              acc_wide,
    input  logic              idx_wide,
    input  logic [WIDE_W-1:0] a_in,
    input  logic [WIDE_W-1:0] x_in,
    output logic              busy,
    output logic              done,
    output logic [WIDE_W-1:0] a_out,
    output logic [WIDE_W-1:0] x_out
);

    localparam int SH = WIDE_W - NARROW_W;

    logic accept, load_en, step_en, wb_en;
    logic op_q, wide_q, xw_q;
    logic [WIDE_W-1:0] a_op_q, x_op_q, a_mask, x_mask;
    logic [WIDE_W-1:0] res_lo, res_hi, a_res_q, x_res_q;

    assign a_mask = acc_wide ? a_in : {{SH{1'b0}}, a_in[NARROW_W-1:0]};
    assign x_mask = (acc_wide && idx_wide) ? x_in
                                           : {{SH{1'b0}}, x_in[NARROW_W-1:0]};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q   <= 1'b0;
            wide_q <= 1'b0;
            xw_q   <= 1'b0;
            a_op_q <= '0;
            x_op_q <= '0;
        end else if (accept) begin
            op_q   <= op_div;
            wide_q <= acc_wide;
            xw_q   <= idx_wide;
            a_op_q <= a_mask;
            x_op_q <= x_mask;
        end
    end

    muldiv_ctrl #(.WIDE_W(WIDE_W), .NARROW_W(NARROW_W)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .wide    (wide_q),
        .busy    (busy),
        .done    (done),
        .accept  (accept),
        .load_en (load_en),
        .step_en (step_en),
        .wb_en   (wb_en)
    );

    muldiv_engine #(.WIDE_W(WIDE_W), .NARROW_W(NARROW_W)) u_engine (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_en (load_en),
        .step_en (step_en),
        .op_div  (op_q),
        .wide    (wide_q),
        .a_op    (a_op_q),
        .x_op    (x_op_q),
        .res_lo  (res_lo),
        .res_hi  (res_hi)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_res_q <= '0;
            x_res_q <= '0;
        end else if (wb_en) begin
            a_res_q <= res_lo;
            if (wide_q && !xw_q) x_res_q <= {{SH{1'b0}}, res_hi[NARROW_W-1:0]};
            else                 x_res_q <= res_hi;
        end
    end

    assign a_out = a_res_q;
    assign x_out = x_res_q;

    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(a_out) || !$stable(x_out)) |-> done);

    p_narrow_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !wide_q) |-> (a_out[WIDE_W-1:NARROW_W] == '0
                               && x_out[WIDE_W-1:NARROW_W] == '0));

    p_mixed_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (done && wide_q && !xw_q) |-> (x_out[WIDE_W-1:NARROW_W] == '0));

    p_divzero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (done && op_q && x_op_q == '0) |->
            (a_out == (wide_q ? {WIDE_W{1'b1}} : {{SH{1'b0}}, {NARROW_W{1'b1}}})));

endmodule

// File: tb/tb_muldiv_unit.sv
module tb_muldiv_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        op_div = 1'b0;
    logic        acc_wide = 1'b0;
    logic        idx_wide = 1'b0;
    logic [15:0] a_in = '0;
    logic [15:0] x_in = '0;
    logic        busy, done;
    logic [15:0] a_out, x_out;

    int total = 0;
    int bad = 0;

    always #2 clk = ~clk;

    muldiv_unit dut (
        .clk(clk), .rst_n(rst_n), .start(start), .op_div(op_div),
        .acc_wide(acc_wide), .idx_wide(idx_wide), .a_in(a_in), .x_in(x_in),
        .busy(busy), .done(done), .a_out(a_out), .x_out(x_out)
    );

    // {op_div, acc_wide, idx_wide, a, x}
    localparam logic [34:0] VEC [12] = '{
        {1'b0, 1'b0, 1'b0, 16'h12FF, 16'h34FF},
        {1'b0, 1'b0, 1'b1, 16'h0007, 16'hAB09},
        {1'b0, 1'b1, 1'b1, 16'hFFFF, 16'hFFFF},
        {1'b0, 1'b1, 1'b1, 16'h1234, 16'h5678},
        {1'b0, 1'b1, 1'b0, 16'hFFFF, 16'h12FF},
        {1'b1, 1'b0, 1'b0, 16'h77C8, 16'h9907},
        {1'b1, 1'b0, 1'b0, 16'h005A, 16'h4400},
        {1'b1, 1'b1, 1'b1, 16'hFFFF, 16'h0010},
        {1'b1, 1'b1, 1'b1, 16'h1234, 16'h1235},
        {1'b1, 1'b1, 1'b1, 16'hBEEF, 16'h0000},
        {1'b1, 1'b1, 1'b0, 16'hABCD, 16'h1200},
        {1'b1, 1'b1, 1'b0, 16'hFFFF, 16'h33FD}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] model(input logic op, input logic aw, input logic xw,
                                          input logic [15:0] a, input logic [15:0] x);
        logic [15:0] am, xm, ao, xo;
        logic [31:0] p;
        am = aw ? a : {8'h00, a[7:0]};
        xm = (aw && xw) ? x : {8'h00, x[7:0]};
        if (!op) begin
            p = {16'h0, am} * {16'h0, xm};
            if (aw) begin ao = p[15:0]; xo = p[31:16]; end
            else begin ao = {8'h00, p[7:0]}; xo = {8'h00, p[15:8]}; end
        end else if (xm == 16'h0) begin
            ao = aw ? 16'hFFFF : 16'h00FF;
            xo = am;
        end else begin
            ao = am / xm;
            xo = am % xm;
        end
        if (aw && !xw) xo[15:8] = 8'h00;
        return {ao, xo};
    endfunction

    function automatic string tag_of(input logic op, input logic aw, input logic xw,
                                     input logic [15:0] x);
        logic zero_div;
        zero_div = (aw && xw) ? (x == 16'h0) : (x[7:0] == 8'h0);
        if (op && zero_div) return "R6";
        if (aw && !xw)      return "R7";
        if (op)             return "R5";
        if (aw)             return "R4";
        return "R3";
    endfunction

    // Issue one operation; returns number of busy cycles until done is seen.
    task automatic run_op(input logic op, input logic aw, input logic xw,
                          input logic [15:0] a, input logic [15:0] x, output int cyc);
        @(negedge clk);
        op_div = op; acc_wide = aw; idx_wide = xw; a_in = a; x_in = x;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cyc = 1;
        while (!done && cyc < 60) begin
            if (!busy) cyc = 100;
            @(negedge clk);
            cyc++;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog: actual=hung expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int cyc;
        logic [31:0] hold;
        // R9: reset state
        repeat (3) @(negedge clk);
        chk("R9 reset", {busy, done, a_out, x_out}, 34'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R9 idle after reset", {busy, done}, 2'b00);

        for (int i = 0; i < 12; i++) begin
            logic op, aw, xw;
            logic [15:0] a, x;
            {op, aw, xw, a, x} = VEC[i];
            run_op(op, aw, xw, a, x, cyc);
            chk(aw ? "R2 latency" : "R1 latency", cyc, aw ? 19 : 11);
            chk(tag_of(op, aw, xw, x), {a_out, x_out}, model(op, aw, xw, a, x));
            @(negedge clk);
            chk("R1 done single pulse", {busy, done}, 2'b00);
        end

        // R2: idx_wide must not change the wide latency
        run_op(1'b0, 1'b1, 1'b0, 16'h0101, 16'h0003, cyc);
        chk("R2 latency idx narrow", cyc, 19);

        // R8: start while busy is ignored
        @(negedge clk);
        op_div = 1'b0; acc_wide = 1'b0; idx_wide = 1'b0;
        a_in = 16'h000C; x_in = 16'h000D; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (3) @(negedge clk);
        op_div = 1'b1; acc_wide = 1'b1; idx_wide = 1'b1;
        a_in = 16'hFFFF; x_in = 16'h0001; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cyc = 5;
        while (!done && cyc < 60) begin
            @(negedge clk);
            cyc++;
        end
        chk("R8 ignored start latency", cyc, 11);
        chk("R8 ignored start result", {a_out, x_out}, model(1'b0, 1'b0, 1'b0, 16'h000C, 16'h000D));
        @(negedge clk);
        chk("R8 no second run", {busy, done}, 2'b00);

        // R8: outputs hold while idle with changing inputs
        hold = {a_out, x_out};
        a_in = 16'h5555; x_in = 16'hAAAA; op_div = 1'b0;
        repeat (6) @(negedge clk);
        chk("R8 hold", {a_out, x_out}, hold);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule